// File: doc/BRIEF.md
# Control and Status Register Access Unit

This unit holds a small set of machine-level control and status registers and carries out the read-modify-write step of a register-access instruction. Each access names a 12-bit register index, an operation (replace, set bits, clear bits or plain read) and a source operand. In the same cycle as the valid strobe, the unit returns the old register value for the destination register, a write-back enable and an illegal-instruction fault flag. The new value is committed at the next rising clock edge.

Every register has a bit mask. The mask is applied to the value that is read, and again to the computed new value. A register is written only if its masked new value differs from its masked old value. An unchanged value never writes and never faults.

The floating-point control register is a combined view of two physical registers: the exception flags and the rounding mode. The interrupt-enable and interrupt-pending registers protect their machine software, timer and external bits. Indices whose top two bits are both set are read-only.

Top module: `csr_unit`

## Requirements
- R1: After reset, every writable register reads as zero and the identification register (index 0xF11) reads as its fixed value, parameter ID_VALUE.
- R2: The op_i encoding selects the new value: 0 replaces the value with the operand, 1 computes old OR operand, 2 computes old AND NOT operand, and 3 leaves the value unchanged (a read).
- R3: The implemented indices use these masks, which apply both to the value read and to the value written: flags 0x001 uses 0x1F, rounding mode 0x002 uses 0x7, floating-point control 0x003 uses 0xFF, scratch 0x340 uses all bits, interrupt-enable 0x304 and interrupt-pending 0x344 use 0xAAA, and identification 0xF11 uses all bits.
- R4: An access to any other index raises fault_o, returns rdata_o = 0 and deasserts wb_en_o.
- R5: An index with bits [11:10] = 2'b11 is read-only. An access that would change it faults and leaves it unchanged.
- R6: When the masked new value equals the masked old value, nothing is written and no fault is raised, even for a read-only index.
- R7: Reading the floating-point control register returns the flags in bits [4:0] and the rounding mode in bits [7:5].
- R8: Writing the floating-point control register stores bits [4:0] into the flags register and bits [7:5] into the rounding-mode register.
- R9: A write to interrupt-enable or interrupt-pending that would change bit 3 (software), bit 7 (timer) or bit 11 (external) faults and is dropped. Changes that touch only the other masked bits are accepted.
- R10: While valid_i is high, wb_en_o equals NOT fault_o, rdata_o carries the old masked value, and both outputs are combinational in the same cycle. A faulting access leaves all state unchanged.
- R11: While valid_i is low, fault_o and wb_en_o are both low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access strobe |
| addr_i | input | 12 | Register index |
| op_i | input | 2 | Operation: 0 replace, 1 set, 2 clear, 3 read |
| operand_i | input | XLEN | Source operand |
| rdata_o | output | XLEN | Old masked value for the destination |
| wb_en_o | output | 1 | Destination write-back enable |
| fault_o | output | 1 | Illegal-instruction fault |

## Verification
The assertions assume that valid_i, addr_i, op_i and operand_i are stable around each rising edge, because the outputs are combinational from those inputs. The bench meets this by changing inputs only at the falling edge and sampling half a period later.

The property that a faulting access leaves state intact assumes that the next access to the same index, if it is a read, comes in the immediately following cycle. The bench checks this case directly with back-to-back read accesses. The sweep covers every implemented index, several unimplemented ones (some inside the read-only range), all four operations and a set of operands chosen to toggle the protected interrupt bits and to leave them alone.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;
  typedef enum logic [1:0] {
    CSR_OP_WRITE = 2'd0,
    CSR_OP_SET   = 2'd1,
    CSR_OP_CLEAR = 2'd2,
    CSR_OP_READ  = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_FLAGS, SEL_RM, SEL_FP, SEL_SCRATCH, SEL_IE, SEL_IP, SEL_ID
  } csr_sel_e;

  localparam logic [11:0] ADDR_FLAGS   = 12'h001;
  localparam logic [11:0] ADDR_RM      = 12'h002;
  localparam logic [11:0] ADDR_FP      = 12'h003;
  localparam logic [11:0] ADDR_IE      = 12'h304;
  localparam logic [11:0] ADDR_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_IP      = 12'h344;
  localparam logic [11:0] ADDR_ID      = 12'hF11;

  localparam int IRQ_SW_BIT = 3;
  localparam int IRQ_TM_BIT = 7;
  localparam int IRQ_EX_BIT = 11;
endpackage

// File: rtl/csr_decode.sv
`timescale 1ns/1ps
module csr_decode
  import csr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W = 3,
  parameter logic [XLEN-1:0] IRQ_MASK = 'hAAA
) (
  input  logic [11:0]     addr_i,
  output csr_sel_e        sel_o,
  output logic [XLEN-1:0] mask_o,
  output logic            read_only_o
);
  localparam logic [XLEN-1:0] M_FLAGS = XLEN'((64'd1 << FLAG_W) - 1);
  localparam logic [XLEN-1:0] M_RM    = XLEN'((64'd1 << RM_W) - 1);
  localparam logic [XLEN-1:0] M_FP    = XLEN'((64'd1 << (FLAG_W + RM_W)) - 1);
  localparam logic [XLEN-1:0] M_ALL   = '1;

  always_comb begin
    sel_o  = SEL_NONE;
    mask_o = '0;
    unique case (addr_i)
      ADDR_FLAGS:   begin sel_o = SEL_FLAGS;   mask_o = M_FLAGS;  end
      ADDR_RM:      begin sel_o = SEL_RM;      mask_o = M_RM;     end
      ADDR_FP:      begin sel_o = SEL_FP;      mask_o = M_FP;     end
      ADDR_SCRATCH: begin sel_o = SEL_SCRATCH; mask_o = M_ALL;    end
      ADDR_IE:      begin sel_o = SEL_IE;      mask_o = IRQ_MASK; end
      ADDR_IP:      begin sel_o = SEL_IP;      mask_o = IRQ_MASK; end
      ADDR_ID:      begin sel_o = SEL_ID;      mask_o = M_ALL;    end
      default:      begin sel_o = SEL_NONE;    mask_o = '0;       end
    endcase
  end

  // top two index bits both set marks the read-only space
  assign read_only_o = &addr_i[11:10];
endmodule

// File: rtl/csr_alu.sv
`timescale 1ns/1ps
module csr_alu
  import csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic [XLEN-1:0] mask_i,
  output logic [XLEN-1:0] new_o
);
  logic [XLEN-1:0] raw;

  always_comb begin
    unique case (op_i)
      CSR_OP_WRITE: raw = operand_i;
      CSR_OP_SET:   raw = old_i | operand_i;
      CSR_OP_CLEAR: raw = old_i & ~operand_i;
      default:      raw = old_i;
    endcase
  end

  assign new_o = raw & mask_i;
endmodule

// File: rtl/csr_store.sv
`timescale 1ns/1ps
module csr_store
  import csr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W = 3,
  parameter logic [XLEN-1:0] ID_VALUE = 'hA11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  csr_sel_e        sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  localparam int NWIDE = 3;

  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rm_q;
  logic [XLEN-1:0]   wide_q [NWIDE];
  logic [NWIDE-1:0]  wide_hit;

  always_comb begin
    wide_hit[0] = (sel_i == SEL_SCRATCH);
    wide_hit[1] = (sel_i == SEL_IE);
    wide_hit[2] = (sel_i == SEL_IP);
  end

  for (genvar g = 0; g < NWIDE; g++) begin : g_wide
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   wide_q[g] <= '0;
      else if (we_i && wide_hit[g])  wide_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      rm_q    <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_FLAGS || sel_i == SEL_FP) flags_q <= wdata_i[FLAG_W-1:0];
      if (sel_i == SEL_RM)                       rm_q    <= wdata_i[RM_W-1:0];
      if (sel_i == SEL_FP)                       rm_q    <= wdata_i[FLAG_W +: RM_W];
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_FLAGS:   rdata_o = XLEN'(flags_q);
      SEL_RM:      rdata_o = XLEN'(rm_q);
      SEL_FP:      rdata_o = XLEN'({rm_q, flags_q});
      SEL_SCRATCH: rdata_o = wide_q[0];
      SEL_IE:      rdata_o = wide_q[1];
      SEL_IP:      rdata_o = wide_q[2];
      SEL_ID:      rdata_o = ID_VALUE;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/csr_unit.sv
`timescale 1ns/1ps
module csr_unit
  import csr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W = 3,
  parameter logic [XLEN-1:0] IRQ_MASK = 'hAAA,
  parameter logic [XLEN-1:0] ID_VALUE = 'hA11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [11:0]     addr_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] operand_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            wb_en_o,
  output logic            fault_o
);
  localparam logic [XLEN-1:0] IRQ_MBITS = XLEN'((64'd1 << IRQ_SW_BIT) |
                                                (64'd1 << IRQ_TM_BIT) |
                                                (64'd1 << IRQ_EX_BIT));

  csr_sel_e        sel;
  logic [XLEN-1:0] mask, raw_old, old_val, new_val;
  logic            read_only, implemented, changed, irq_bad, we;

  csr_decode #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W), .IRQ_MASK(IRQ_MASK)) u_decode (
    .addr_i     (addr_i),
    .sel_o      (sel),
    .mask_o     (mask),
    .read_only_o(read_only)
  );

  csr_store #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W), .ID_VALUE(ID_VALUE)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .sel_i  (sel),
    .wdata_i(new_val),
    .rdata_o(raw_old)
  );

  assign old_val = raw_old & mask;

  csr_alu #(.XLEN(XLEN)) u_alu (
    .op_i     (csr_op_e'(op_i)),
    .old_i    (old_val),
    .operand_i(operand_i),
    .mask_i   (mask),
    .new_o    (new_val)
  );

  assign implemented = (sel != SEL_NONE);
  assign changed     = (new_val != old_val);
  assign irq_bad     = (sel == SEL_IE || sel == SEL_IP) && |((new_val ^ old_val) & IRQ_MBITS);
  assign fault_o     = valid_i && (!implemented || (changed && read_only) || irq_bad);
  assign we          = valid_i && implemented && changed && !fault_o;
  assign wb_en_o     = valid_i && !fault_o;
  assign rdata_o     = old_val;
endmodule

// File: rtl/csr_unit_chk.sv
`timescale 1ns/1ps
module csr_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [11:0]     addr_i,
  input logic [1:0]      op_i,
  input logic [XLEN-1:0] operand_i,
  input logic [XLEN-1:0] rdata_o,
  input logic            wb_en_o,
  input logic            fault_o
);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!fault_o && !wb_en_o));

  p_wb_or_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (wb_en_o != fault_o));

  p_ro_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&addr_i[11:10]) && op_i == 2'd0 && operand_i != rdata_o) |-> fault_o);

  p_fault_keeps_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fault_o) |=>
      (!(valid_i && op_i == 2'd3 && addr_i == $past(addr_i)) || rdata_o == $past(rdata_o)));

  p_read_op_no_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3 && wb_en_o) |=>
      (!(valid_i && op_i == 2'd3 && addr_i == $past(addr_i)) || rdata_o == $past(rdata_o)));
endmodule

bind csr_unit csr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .addr_i   (addr_i),
  .op_i     (op_i),
  .operand_i(operand_i),
  .rdata_o  (rdata_o),
  .wb_en_o  (wb_en_o),
  .fault_o  (fault_o)
);

// File: tb/csr_unit_bench.sv
`timescale 1ns/1ps
module csr_unit_bench;
  localparam logic [31:0] ID_VAL = 32'h0000_0A11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  op_i = '0;
  logic [31:0] operand_i = '0;
  logic [31:0] rdata_o;
  logic        wb_en_o, fault_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [4:0]  m_flags;
  logic [2:0]  m_rm;
  logic [31:0] m_scr, m_ie, m_ip;

  always #10 clk_i = ~clk_i;

  csr_unit #(.XLEN(32), .ID_VALUE(ID_VAL)) u_csr_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
    .op_i(op_i), .operand_i(operand_i), .rdata_o(rdata_o),
    .wb_en_o(wb_en_o), .fault_o(fault_o)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic [1:0] op, input logic [31:0] d,
                        input string tag);
    logic [31:0] msk, old, nv;
    logic impl, exp_f;
    impl = 1'b1;
    case (a)
      12'h001: begin msk = 32'h1F;  old = {27'd0, m_flags}; end
      12'h002: begin msk = 32'h7;   old = {29'd0, m_rm}; end
      12'h003: begin msk = 32'hFF;  old = {24'd0, m_rm, m_flags}; end
      12'h340: begin msk = '1;      old = m_scr; end
      12'h304: begin msk = 32'hAAA; old = m_ie & 32'hAAA; end
      12'h344: begin msk = 32'hAAA; old = m_ip & 32'hAAA; end
      12'hF11: begin msk = '1;      old = ID_VAL; end
      default: begin msk = '0;      old = '0; impl = 1'b0; end
    endcase
    case (op)
      2'd0: nv = d;
      2'd1: nv = old | d;
      2'd2: nv = old & ~d;
      default: nv = old;
    endcase
    nv &= msk;
    exp_f = !impl || (nv != old && a[11:10] == 2'b11) ||
            ((a == 12'h304 || a == 12'h344) && ((nv ^ old) & 32'h888) != 0);
    @(negedge clk_i);
    valid_i = 1'b1; addr_i = a; op_i = op; operand_i = d;
    #5;
    check(tag, "rdata", rdata_o, old);
    check(tag, "fault", {31'd0, fault_o}, {31'd0, exp_f});
    check(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, !exp_f});
    @(posedge clk_i);
    #1 valid_i = 1'b0;
    if (!exp_f && nv != old) begin
      case (a)
        12'h001: m_flags = nv[4:0];
        12'h002: m_rm = nv[2:0];
        12'h003: begin m_flags = nv[4:0]; m_rm = nv[7:5]; end
        12'h340: m_scr = nv;
        12'h304: m_ie = nv;
        12'h344: m_ip = nv;
        default: ;
      endcase
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [11];
    logic [31:0] opnds [8];
    string       tags  [11];
    addrs = '{12'h001, 12'h002, 12'h003, 12'h340, 12'h304, 12'h344, 12'hF11,
              12'h000, 12'h305, 12'hC00, 12'hF12};
    tags  = '{"R3", "R3", "R7", "R2", "R9", "R9", "R5", "R4", "R4", "R4", "R4"};
    opnds = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h888, 32'h222, 32'h1F, 32'hE0, 32'h5};
    m_flags = '0; m_rm = '0; m_scr = '0; m_ie = '0; m_ip = '0;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: reset values
    for (int i = 0; i < 7; i++) access(addrs[i], 2'd3, 32'h0, "R1");

    // R11: idle outputs stay low
    @(negedge clk_i); addr_i = 12'h000; op_i = 2'd0; #5;
    check("R11", "fault idle", {31'd0, fault_o}, 32'd0);
    check("R11", "wb idle", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk_i); addr_i = 12'h340; operand_i = 32'hDEAD_BEEF; op_i = 2'd0;
    @(negedge clk_i);
    access(12'h340, 2'd3, 32'h0, "R11");

    // R8: combined write splits into flags and rounding mode
    access(12'h003, 2'd0, 32'hFFFF_FFAB, "R8");
    access(12'h001, 2'd3, 32'h0, "R8");
    access(12'h002, 2'd3, 32'h0, "R8");
    // R7: combined read after separate writes
    access(12'h001, 2'd0, 32'h15, "R7");
    access(12'h002, 2'd0, 32'h2, "R7");
    access(12'h003, 2'd3, 32'h0, "R7");

    // R6: unchanged value on read-only index: no fault
    access(12'hF11, 2'd0, ID_VAL, "R6");
    access(12'hF11, 2'd1, 32'h0, "R6");
    access(12'hF11, 2'd2, 32'h0, "R6");
    // R5: changing read-only faults and is dropped
    access(12'hF11, 2'd1, 32'h1000, "R5");
    access(12'hF11, 2'd3, 32'h0, "R5");

    // R9: protected interrupt bits
    access(12'h304, 2'd0, 32'h222, "R9");
    access(12'h304, 2'd1, 32'h8, "R9");
    access(12'h304, 2'd3, 32'h0, "R9");
    access(12'h344, 2'd1, 32'h80, "R9");
    access(12'h344, 2'd1, 32'h800, "R9");
    access(12'h344, 2'd0, 32'h202, "R9");
    access(12'h344, 2'd3, 32'h0, "R9");

    // R10: faulting access leaves state; back-to-back reads
    access(12'h340, 2'd0, 32'h1234_5678, "R10");
    access(12'h340, 2'd3, 32'h0, "R10");
    access(12'h340, 2'd3, 32'h0, "R10");

    // R2/R3/R4/R5/R7/R9 sweep over indices, ops and operands
    for (int ai = 0; ai < 11; ai++)
      for (int op = 0; op < 4; op++)
        for (int oi = 0; oi < 8; oi++) begin
          access(addrs[ai], op[1:0], opnds[oi], tags[ai]);
          access(addrs[ai], 2'd3, 32'h0, tags[ai]);
        end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule